// File: doc/BRIEF.md
# Three-Key Keypad Code Lock

This block watches a keypad and opens a door when a fixed three-key code is entered. Each clock it samples a key-valid strobe and two key-identity lines. It steps through a small state machine and raises an unlock output for exactly one cycle once the third key of the code has been accepted. A press counter output feeds an external display decoder, so the user can see how many keys have been entered in the current attempt.

Every key press is counted, whether it is right or wrong. One group of states follows a correct prefix of the code and a second group follows an attempt that has already gone wrong. As a result a bad attempt is only dropped after its third key, and the display never shows where the mistake was. Both outputs depend only on the registered state, so they change one cycle after the key that caused the change.

The code is B, then A, then B. After an open cycle, or after the third key of a failed attempt, the machine is back at idle and waits for a new attempt.

Top module: `keyseq_lock`

## Requirements
- R1: Driving `rst_n` low forces the idle state at once, without waiting for a clock edge. In idle, `press_cnt` is 0 and `unlock` is 0.
- R2: A key is seen only on a rising edge where `key_vld` is 1. Key A is `key_vld,key_a,key_b` = 1,1,0 and key B is 1,0,1. While `key_vld` is 0, `key_a` and `key_b` are ignored, and both outputs hold their values in every state except the open state.
- R3: The sequence B, A, B makes `unlock` go high for exactly one cycle, starting in the cycle after the edge that samples the third key. In that cycle `press_cnt` is 3.
- R4: After the first key of an attempt `press_cnt` is 1, and after the second key it is 2, whether or not those keys were correct.
- R5: An attempt whose three keys are not B, A, B returns to idle on the edge that samples its third key. `press_cnt` goes to 0 and `unlock` never rises.
- R6: A valid strobe with any identity combination other than A or B (1,0,0 or 1,1,1) counts as a key press that does not match the expected key.
- R7: From the open state the machine returns to idle on the next edge whatever the inputs are. A key sampled on that edge is not counted.
- R8: The upper two bits of `press_cnt` are always 0. `unlock` is high only while `press_cnt` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Active-low reset; takes effect at once when asserted, released synchronously |
| key_vld | input | 1 | Key strobe, one cycle per press |
| key_a | input | 1 | Identity line for key A |
| key_b | input | 1 | Identity line for key B |
| unlock | output | 1 | High for one cycle after a correct code |
| press_cnt | output | 4 | Number of keys entered in the current attempt |

## Verification
The state is not visible at the ports except through the count and unlock, so a wrong transition shows up on `press_cnt` in the cycle right after the key that caused it. A confusion between the correct-prefix path and the wrong-key path shows up only after the third key: either `unlock` rises when it should stay low, or the count reads 3 instead of 0. The bench therefore runs every three-key attempt built from A, B and both odd strobe combinations. Between attempts it places idle gaps with changing identity lines, and it checks both outputs after every edge.

// File: rtl/keyseq_pkg.sv
package keyseq_pkg;

  localparam int STATE_W = 3;

  // Encoded state of the lock; values are fixed so that the count decode stays small
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'b000,
    ST_OK1  = 3'b001,
    ST_OK2  = 3'b010,
    ST_OPEN = 3'b011,
    ST_BAD1 = 3'b100,
    ST_BAD2 = 3'b101
  } lock_state_e;

  // Classified key seen on one clock edge
  typedef enum logic [1:0] {
    KEY_NONE = 2'd0,
    KEY_A    = 2'd1,
    KEY_B    = 2'd2,
    KEY_ODD  = 2'd3
  } key_cls_e;

endpackage

// File: rtl/keyseq_decode.sv
module keyseq_decode
  import keyseq_pkg::*;
(
  input  logic     key_vld,
  input  logic     key_a,
  input  logic     key_b,
  output key_cls_e key_cls
);

  always_comb begin
    if (!key_vld) begin
      key_cls = KEY_NONE;
    end else begin
      unique case ({key_a, key_b})
        2'b10:   key_cls = KEY_A;
        2'b01:   key_cls = KEY_B;
        default: key_cls = KEY_ODD;
      endcase
    end
  end

endmodule

// File: rtl/keyseq_next.sv
module keyseq_next
  import keyseq_pkg::*;
(
  input  lock_state_e state_q,
  input  key_cls_e    key_cls,
  output lock_state_e state_d,
  output logic        state_en
);

  logic pressed;
  assign pressed = (key_cls != KEY_NONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (key_cls == KEY_B)  state_d = ST_OK1;
        else if (pressed)      state_d = ST_BAD1;
      end
      ST_OK1: begin
        if (key_cls == KEY_A)  state_d = ST_OK2;
        else if (pressed)      state_d = ST_BAD2;
      end
      ST_OK2: begin
        if (key_cls == KEY_B)  state_d = ST_OPEN;
        else if (pressed)      state_d = ST_IDLE;
      end
      ST_OPEN: state_d = ST_IDLE;
      ST_BAD1: begin
        if (pressed)           state_d = ST_BAD2;
      end
      ST_BAD2: begin
        if (pressed)           state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Clock enable: the register only loads when the state actually moves
  assign state_en = (state_d != state_q);

endmodule

// File: rtl/keyseq_out.sv
module keyseq_out
  import keyseq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  lock_state_e       state_q,
  output logic              unlock,
  output logic [CNT_W-1:0]  press_cnt
);

  localparam int BASE_W = 2;

  logic [BASE_W-1:0] cnt_base;

  always_comb begin
    unique case (state_q)
      ST_OK1, ST_BAD1: cnt_base = 2'd1;
      ST_OK2, ST_BAD2: cnt_base = 2'd2;
      ST_OPEN:         cnt_base = 2'd3;
      default:         cnt_base = 2'd0;
    endcase
  end

  assign unlock = (state_q == ST_OPEN);

  generate
    if (CNT_W > BASE_W) begin : g_pad
      assign press_cnt = {{(CNT_W-BASE_W){1'b0}}, cnt_base};
    end else begin : g_trim
      assign press_cnt = cnt_base[CNT_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/keyseq_lock.sv
module keyseq_lock
  import keyseq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_vld,
  input  logic             key_a,
  input  logic             key_b,
  output logic             unlock,
  output logic [CNT_W-1:0] press_cnt
);

  key_cls_e    key_cls;
  lock_state_e state_q;
  lock_state_e state_d;
  logic        state_en;

  keyseq_decode u_decode (
    .key_vld (key_vld),
    .key_a   (key_a),
    .key_b   (key_b),
    .key_cls (key_cls)
  );

  keyseq_next u_next (
    .state_q  (state_q),
    .key_cls  (key_cls),
    .state_d  (state_d),
    .state_en (state_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  keyseq_out #(.CNT_W(CNT_W)) u_out (
    .state_q   (state_q),
    .unlock    (unlock),
    .press_cnt (press_cnt)
  );

  AST_UNLOCK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> !unlock); // R3

  AST_OPEN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> (press_cnt == '0)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_vld && !unlock) |=> $stable(press_cnt)); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (key_vld && !unlock) |=>
      ((press_cnt == $past(press_cnt) + CNT_W'(1)) || (press_cnt == '0))); // R4

  AST_UNLOCK_AT_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |-> (press_cnt == CNT_W'(3))); // R8

endmodule

// File: tb/keyseq_lock_tb.sv
`timescale 1ns/100ps
module keyseq_lock_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       key_vld;
  logic       key_a;
  logic       key_b;
  logic       unlock;
  logic [3:0] press_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  keyseq_lock u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_vld   (key_vld),
    .key_a     (key_a),
    .key_b     (key_b),
    .unlock    (unlock),
    .press_cnt (press_cnt)
  );

  task automatic check(input string req, input int exp_cnt, input bit exp_unl);
    n_tests++;
    if (press_cnt !== 4'(exp_cnt) || unlock !== exp_unl) begin
      n_fail++;
      $display("FAIL %s: cnt=%0d unlock=%0b expected cnt=%0d unlock=%0b",
               req, press_cnt, unlock, exp_cnt, exp_unl);
    end
  endtask

  // Key code: 0=A (110) 1=B (101) 2=odd (100) 3=odd (111)
  task automatic drive_key(input int k);
    @(negedge clk);
    key_vld = 1'b1;
    case (k)
      0: begin key_a = 1'b1; key_b = 1'b0; end
      1: begin key_a = 1'b0; key_b = 1'b1; end
      2: begin key_a = 1'b0; key_b = 1'b0; end
      default: begin key_a = 1'b1; key_b = 1'b1; end
    endcase
    @(posedge clk);
    #1;
  endtask

  task automatic drive_idle(input int junk);
    @(negedge clk);
    key_vld = 1'b0;
    key_a   = junk[0];
    key_b   = junk[1];
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; key_vld = 1'b0; key_a = 1'b0; key_b = 1'b0;
    #1;
    check("R1 reset", 0, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset held", 0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // Sweep all three-key attempts over four key kinds, with and without gaps
    for (int gap = 0; gap < 3; gap += 2) begin
      for (int s = 0; s < 64; s++) begin
        int k0, k1, k2;
        bit good;
        k0 = s % 4; k1 = (s / 4) % 4; k2 = (s / 16) % 4;
        drive_key(k0);
        check((k0 >= 2) ? "R6 first odd" : "R4 first", 1, 1'b0);
        for (int g = 0; g < gap; g++) begin
          drive_idle(s + g);
          check("R2 hold after 1", 1, 1'b0);
        end
        drive_key(k1);
        check((k1 >= 2) ? "R6 second odd" : "R4 second", 2, 1'b0);
        for (int g = 0; g < gap; g++) begin
          drive_idle(s + g + 1);
          check("R2 hold after 2", 2, 1'b0);
        end
        drive_key(k2);
        good = (k0 == 1) && (k1 == 0) && (k2 == 1);
        if (good) check("R3 correct code", 3, 1'b1);
        else      check((k2 >= 2 || k1 >= 2 || k0 >= 2) ? "R6 odd attempt" : "R5 wrong code", 0, 1'b0);
        drive_idle(s);
        check(good ? "R3 single pulse" : "R5 stays idle", 0, 1'b0);
        check("R8 upper bits", int'(press_cnt[1:0]), 1'b0);
      end
    end

    // Key pressed during the open cycle is not counted
    drive_key(1); drive_key(0); drive_key(1);
    check("R3 open", 3, 1'b1);
    drive_key(1);
    check("R7 key ignored in open", 0, 1'b0);
    drive_key(1);
    check("R7 next key counts", 1, 1'b0);

    // Asynchronous reset in the middle of an attempt
    drive_key(0);
    check("R4 second before reset", 2, 1'b0);
    @(negedge clk);
    key_vld = 1'b0;
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async reset", 0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    drive_key(1);
    check("R1 fresh attempt", 1, 1'b0);

    done = 1'b1;
  end

  initial begin
    int cycles = 0;
    while (!done && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: cnt=%0d unlock=%0b expected run to finish", press_cnt, unlock);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule